// File: doc/BRIEF.md
# Double-Buffered 10-Bit Pulse-Width Modulator

This block drives one pulse-width modulated output from a 10-bit time base. The time base is an 8-bit period counter with a 2-bit sub-count below it. The sub-count advances on every clock and carries into the counter. A period ends when the upper counter equals the programmed period value while the sub-count is at its top value. Each period therefore lasts (period + 1) × 4 clocks.

Software writes three registers. The first is an 8-bit period value. The second is the upper 8 bits of the duty value. The third is a small control word holding the enable bit and the two low duty bits. These writes land in a master duty register. The master value is copied into a working (slave) duty register only at a period boundary, so a duty change never cuts a pulse short or stretches it. The output is set at each boundary and cleared when the time base reaches the working duty value. Clearing the enable bit holds the time base at zero and forces the output low.

Top module: `pwm_dbuf10`

## Requirements
- R1: While reset is asserted and after it is released with no register written, `pwm_o` is low.
- R2: With the block enabled and a nonzero duty, the output rises once every (P + 1) × 4 clocks, where P is the period register value.
- R3: The output stays high for exactly D clocks of each period, where D = {duty_hi, ctl_wdata[2:1]} and 0 < D < (P + 1) × 4.
- R4: A duty value of (P + 1) × 4 or more keeps the output high on every clock of every period.
- R5: A duty value of zero keeps the output low on every clock, including the period boundary and the clock where the block is enabled.
- R6: A duty write made in the middle of a period does not change that period's pulse. The new value applies from the next period boundary onward.
- R7: Writing the control word with bit 0 cleared drives the output low from the second clock edge after the write and keeps it low while disabled.
- R8: After a control write that sets bit 0 while disabled, the output is still low after the first clock edge. With a nonzero duty it is high after the second edge, and the first pulse uses the duty held at that time.
- R9: The two low duty bits come from control bits 2:1 and the enable from control bit 0. The upper eight duty bits come from the duty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 8 | Period value P |
| dhi_we | input | 1 | Upper duty register write strobe |
| dhi_wdata | input | 8 | Upper 8 bits of the duty value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Bit 0 enable, bits 2:1 low duty bits |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume the period value is not lowered below the running counter in the middle of a period. They also assume no duty write lands in the same clock as a boundary, because the boundary copy uses the registered master value. The stimulus changes the period only while the block is disabled. It issues mid-period duty writes only right after an observed rising edge, well before the next boundary. Each write strobe is held for exactly one clock and is driven between clock edges.

// File: rtl/pwm_dbuf10_pkg.sv
package pwm_dbuf10_pkg;
  localparam int DEF_PER_W  = 8;
  localparam int DEF_SUB_W  = 2;
  // control word layout: enable at bit 0, low duty bits above it
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_LO_LSB = 1;
endpackage

// File: rtl/pwm_dbuf10_regs.sv
module pwm_dbuf10_regs #(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = PER_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_wdata,
  input  logic             dhi_we,
  input  logic [PER_W-1:0] dhi_wdata,
  input  logic             ctl_we,
  input  logic [SUB_W:0]   ctl_wdata,
  output logic [PER_W-1:0] per_q,
  output logic [DW-1:0]    duty_m,
  output logic             en_q
);
  import pwm_dbuf10_pkg::*;

  logic [PER_W-1:0] dhi_q, dhi_nxt, per_nxt;
  logic [SUB_W-1:0] dlo_q, dlo_nxt;
  logic             en_nxt;

  always_comb begin
    per_nxt = per_q;
    dhi_nxt = dhi_q;
    dlo_nxt = dlo_q;
    en_nxt  = en_q;
    if (per_we) per_nxt = per_wdata;
    if (dhi_we) dhi_nxt = dhi_wdata;
    if (ctl_we) begin
      en_nxt  = ctl_wdata[CTL_EN_BIT];
      dlo_nxt = ctl_wdata[CTL_LO_LSB +: SUB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      dhi_q <= '0;
      dlo_q <= '0;
      en_q  <= 1'b0;
    end else begin
      per_q <= per_nxt;
      dhi_q <= dhi_nxt;
      dlo_q <= dlo_nxt;
      en_q  <= en_nxt;
    end
  end

  assign duty_m = {dhi_q, dlo_q};

  a_r9_ctl_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (en_q == $past(ctl_wdata[CTL_EN_BIT])) &&
               (duty_m[SUB_W-1:0] == $past(ctl_wdata[CTL_LO_LSB +: SUB_W])));
endmodule

// File: rtl/pwm_dbuf10_tbase.sv
module pwm_dbuf10_tbase #(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = PER_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] per,
  output logic [DW-1:0]    tb_nxt,
  output logic             bnd
);
  logic [DW-1:0] tb_q;
  logic          run_q, run_nxt;
  logic          at_end;

  // end of period: upper part matches period while sub-count is at its top
  assign at_end = (tb_q == {per, {SUB_W{1'b1}}});

  always_comb begin
    bnd     = en && (!run_q || at_end);
    run_nxt = en;
    if (!en || bnd) tb_nxt = '0;
    else            tb_nxt = tb_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q  <= '0;
      run_q <= 1'b0;
    end else begin
      tb_q  <= tb_nxt;
      run_q <= run_nxt;
    end
  end

  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tb_q == '0) && !run_q);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && at_end) |=> (tb_q == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !at_end) |=> (tb_q == $past(tb_q) + 1'b1));
endmodule

// File: rtl/pwm_dbuf10_olatch.sv
module pwm_dbuf10_olatch #(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = PER_W + SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bnd,
  input  logic [DW-1:0] duty_m,
  input  logic [DW-1:0] tb_nxt,
  output logic          out_q
);
  logic [DW-1:0] slave_q, slave_nxt;
  logic          out_nxt;

  always_comb begin
    slave_nxt = slave_q;
    out_nxt   = out_q;
    if (!en) begin
      out_nxt = 1'b0;
    end else if (bnd) begin
      slave_nxt = duty_m;
      out_nxt   = (duty_m != '0);
    end else if (tb_nxt == slave_q) begin
      out_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= '0;
      out_q   <= 1'b0;
    end else begin
      slave_q <= slave_nxt;
      out_q   <= out_nxt;
    end
  end

  a_r6_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(slave_q));
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (slave_q == $past(duty_m)));
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && (duty_m == '0)) |=> !out_q);
  a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_q);
endmodule

// File: rtl/pwm_dbuf10.sv
module pwm_dbuf10
  import pwm_dbuf10_pkg::*;
#(
  parameter int PER_W = DEF_PER_W,
  parameter int SUB_W = DEF_SUB_W,
  localparam int DW   = PER_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_wdata,
  input  logic             dhi_we,
  input  logic [PER_W-1:0] dhi_wdata,
  input  logic             ctl_we,
  input  logic [SUB_W:0]   ctl_wdata,
  output logic             pwm_o
);
  logic [1:0]       rs_q;
  logic             rst_s_n;
  logic [PER_W-1:0] per_q;
  logic [DW-1:0]    duty_m, tb_nxt;
  logic             en_q, bnd;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pwm_dbuf10_regs #(.PER_W(PER_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .dhi_we(dhi_we), .dhi_wdata(dhi_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .per_q(per_q), .duty_m(duty_m), .en_q(en_q)
  );

  pwm_dbuf10_tbase #(.PER_W(PER_W), .SUB_W(SUB_W)) u_tbase (
    .clk(clk), .rst_n(rst_s_n), .en(en_q), .per(per_q),
    .tb_nxt(tb_nxt), .bnd(bnd)
  );

  pwm_dbuf10_olatch #(.PER_W(PER_W), .SUB_W(SUB_W)) u_olatch (
    .clk(clk), .rst_n(rst_s_n), .en(en_q), .bnd(bnd),
    .duty_m(duty_m), .tb_nxt(tb_nxt), .out_q(pwm_o)
  );

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_s_n |=> !pwm_o);
endmodule

// File: tb/pwm_dbuf10_tb.sv
module pwm_dbuf10_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_we = 1'b0, dhi_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] per_wdata = '0, dhi_wdata = '0;
  logic [2:0] ctl_wdata = '0;
  logic       pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit arm = 1'b0;

  typedef struct { int hi; int per; string req; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  pwm_dbuf10 u_dut (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .dhi_we(dhi_we), .dhi_wdata(dhi_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_per(input logic [7:0] v);
    per_wdata = v; per_we = 1'b1;
    @(negedge clk); per_we = 1'b0;
  endtask
  task automatic wr_dhi(input logic [7:0] v);
    dhi_wdata = v; dhi_we = 1'b1;
    @(negedge clk); dhi_we = 1'b0;
  endtask
  task automatic wr_ctl(input logic [1:0] lo, input logic en);
    ctl_wdata = {lo, en}; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic push(input int hi, input int per, input string req);
    item_t it;
    it.hi = hi; it.per = per; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain(input int limit, input string req);
    int n = 0;
    while (exp_q.size() > 0 && n < limit) begin
      @(negedge clk); n++;
    end
    chk(exp_q.size() == 0, {req, " pulses outstanding"}, exp_q.size(), 0);
  endtask

  // all of n samples must equal v
  task automatic hold_check(input int n, input logic v, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o !== v) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  // monitor: measures each pulse from one rise to the next
  initial begin
    logic prev = 1'b0;
    bit   meas = 1'b0;
    int   cnt = 0, hi = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (!arm) begin
        meas = 1'b0;
        prev = pwm_o;
      end else begin
        if (!prev && pwm_o) begin
          if (meas && exp_q.size() > 0) begin
            it = exp_q.pop_front();
            chk(hi == it.hi, {it.req, " high time"}, hi, it.hi);
            chk(cnt == it.per, {it.req, " period"}, cnt, it.per);
          end
          meas = 1'b1; cnt = 1; hi = 1;
        end else if (meas) begin
          cnt++;
          if (pwm_o) hi++;
        end
        prev = pwm_o;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 during reset", pwm_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 after reset", pwm_o, 0);

    // R2 R3 R9: P=3 -> 16 clocks, D = {2, 01} = 9
    wr_per(8'd3);
    wr_dhi(8'd2);
    arm = 1'b1;
    push(9, 16, "R3 R9 D9");
    push(9, 16, "R2 D9");
    push(9, 16, "R2 R3 D9");
    wr_ctl(2'b01, 1'b1);
    drain(200, "R2");

    // R6: mid-period write right after a rise, D becomes {1,01} = 5
    push(9, 16, "R6 current period kept");
    push(5, 16, "R6 new duty applied");
    push(5, 16, "R6 new duty steady");
    wr_dhi(8'd1);
    drain(200, "R6");
    arm = 1'b0;

    // R4: duty equal to full count, then maximum duty
    wr_dhi(8'd4);
    wr_ctl(2'b00, 1'b1);
    repeat (40) @(negedge clk);
    hold_check(32, 1'b1, "R4 duty equals period");
    wr_dhi(8'hFF);
    wr_ctl(2'b11, 1'b1);
    repeat (40) @(negedge clk);
    hold_check(32, 1'b1, "R4 duty above period");

    // R7: disable while output is high
    ctl_wdata = 3'b110; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
    chk(pwm_o == 1'b1, "R7 one edge after write", pwm_o, 1);
    @(negedge clk);
    chk(pwm_o == 1'b0, "R7 two edges after write", pwm_o, 0);
    hold_check(24, 1'b0, "R7 held low while disabled");

    // R5: zero duty, no glitch at enable or boundaries
    wr_dhi(8'd0);
    wr_ctl(2'b00, 1'b1);
    hold_check(48, 1'b0, "R5 zero duty");
    wr_ctl(2'b00, 1'b0);
    repeat (3) @(negedge clk);

    // R8: enable with P=7 (32 clocks), D = {0,11} = 3
    wr_per(8'd7);
    arm = 1'b1;
    push(3, 32, "R8 first pulse");
    push(3, 32, "R8 R2 second pulse");
    ctl_wdata = 3'b111; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
    chk(pwm_o == 1'b0, "R8 low after first edge", pwm_o, 0);
    @(negedge clk);
    chk(pwm_o == 1'b1, "R8 high after second edge", pwm_o, 1);
    drain(300, "R8");
    arm = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule